// File: doc/BRIEF.md
# Fan Speed PWM Generator

This block drives one 2-wire cooling fan with a pulse-width modulated signal. The period is fixed at 40 ms and cannot be changed. Software sets the fan speed by writing an 8-bit duty value. During each period the output stays high for a share of the period equal to the duty value divided by 255. A prescaler derives each of the 255 duty steps from the block clock. The `CLK_HZ` parameter sets the prescaler, and `PERIOD_HZ` (25, which gives 40 ms) sets the period rate.

Software reaches the block through two 32-bit word registers on a simple register bus. The block accepts a request in every cycle (`bus_ready` is tied high). The control word at byte offset 0x0 holds the run bit, a mode bit and the duty value. The word at offset 0x4 holds a 16-bit maximum-speed setting. The block stores that setting and returns it on reads, but it has no effect on the output.

A duty write has no shadow register. The comparator uses the new value at once, so only the period in progress may show a mix of the old and new settings. Clearing the run bit forces the output low at once and discards the position in the period.

Top module: `fanpwm_ctrl`

## Requirements
- R1: After reset, `pwm_out` is 0 and both registers read back as 0.
- R2: In the control word (offset 0x0), bit 0 is run (1 = running), bit 1 is mode (only 0, 2-wire, is defined) and bits 23:16 are duty. Every other bit reads 0 and ignores writes, so writing 0xFFFFFFFF reads back 0x00FF0003.
- R3: The low 16 bits of the word at offset 0x4 store a maximum-speed value (for example 4000) and read back unchanged. Bits 31:16 read 0, so writing 0xFFFFFFFF reads back 0x0000FFFF.
- R4: A read at any other offset (0x8, 0xC) returns 0. A write there changes neither register.
- R5: `bus_ready` is always 1. A read accepted at a clock edge gives `rd_valid` = 1 with its data in the cycle that follows. A write never raises `rd_valid`.
- R6: One period lasts 255 × PRESC clock cycles, where PRESC = CLK_HZ / (PERIOD_HZ × 255). With CLK_HZ = 12750, PRESC is 2 and a period is 510 cycles. A new period starts right after the last step of the previous one.
- R7: While running, the output is high for the first duty × PRESC cycles of each period and low for the rest. Duty 0 gives a constant low and duty 255 a constant high.
- R8: A write that clears the run bit drives `pwm_out` low in the next cycle. A later write that sets the run bit starts a fresh period from step 0.
- R9: A duty write while running applies from the next cycle, with no wait for the period to end. Every full period after it follows the new duty exactly.
- R10: The mode bit has no effect on the output waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| pwm_out | output | 1 | Active-high fan drive |

## Verification
The bench targets the following corner cases:

- **Duty 0 and duty 255.** An off-by-one comparator would let a one-step sliver of high or low through at either end.
- **Disable and re-enable in the middle of a period.** A design that kept the step count would restart part-way through, so the first low would come early.
- **Duty lowered in the middle of a period.** A design with a shadow register would hold the old high time until the boundary, and a design that never reloaded would keep the old ratio afterwards.
- **Register decode.** Writes to undefined offsets and reserved bits are checked. Careless decoding would alias these writes into the real registers or leak them into reads.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned DUTY_W    = 8;
    localparam int unsigned SPEED_W   = 16;
    // steps per period: the full duty range
    localparam int unsigned STEPS     = (1 << DUTY_W) - 1;
    // word indices of the register words
    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_SPEED = 1;
    // control word field positions
    localparam int unsigned RUN_BIT   = 0;
    localparam int unsigned MODE_BIT  = 1;
    localparam int unsigned DUTY_LSB  = 16;
endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                run,
    output logic [DUTY_W-1:0]   duty,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic                run;
        logic                mode;
        logic [DUTY_W-1:0]   duty;
        logic [SPEED_W-1:0]  speed;
        logic                rd_valid;
        logic [DATA_W-1:0]   rd_data;
    } regs_t;

    regs_t r_d, r_q;
    logic [WORD_W-1:0] word;
    logic              unused_bits;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = bus_valid && !bus_write;
        r_d.rd_data  = '0;
        if (bus_valid && bus_write) begin
            if (word == WORD_W'(IDX_CTRL)) begin
                r_d.run  = bus_wdata[RUN_BIT];
                r_d.mode = bus_wdata[MODE_BIT];
                r_d.duty = bus_wdata[DUTY_LSB +: DUTY_W];
            end else if (word == WORD_W'(IDX_SPEED)) begin
                r_d.speed = bus_wdata[SPEED_W-1:0];
            end
        end else if (bus_valid) begin
            if (word == WORD_W'(IDX_CTRL)) begin
                r_d.rd_data[RUN_BIT]               = r_q.run;
                r_d.rd_data[MODE_BIT]              = r_q.mode;
                r_d.rd_data[DUTY_LSB +: DUTY_W]    = r_q.duty;
            end else if (word == WORD_W'(IDX_SPEED)) begin
                r_d.rd_data[SPEED_W-1:0] = r_q.speed;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run      = r_q.run;
    assign duty     = r_q.duty;
    assign rd_valid = r_q.rd_valid;
    assign rd_data  = r_q.rd_data;
endmodule

// File: rtl/fanpwm_prescaler.sv
module fanpwm_prescaler #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_t;

    pre_t p_d, p_q;

    assign tick = run && (p_q.pre == PW'(DIV - 1));

    always_comb begin
        p_d = p_q;
        if (!run || tick) p_d.pre = '0;
        else              p_d.pre = p_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/fanpwm_gen.sv
module fanpwm_gen
    import fanpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty,
    output logic [DUTY_W-1:0] step,
    output logic              pwm_out
);
    localparam logic [DUTY_W-1:0] LAST_STEP = DUTY_W'(STEPS - 1);

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!run)
            g_d.cnt = '0;
        else if (tick)
            g_d.cnt = (g_q.cnt == LAST_STEP) ? '0 : g_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign step    = g_q.cnt;
    assign pwm_out = run && (g_q.cnt < duty);
endmodule

// File: rtl/fanpwm_ctrl.sv
module fanpwm_ctrl
    import fanpwm_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned PERIOD_HZ = 25,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              pwm_out
);
    localparam int unsigned RAW_DIV = CLK_HZ / (PERIOD_HZ * STEPS);
    localparam int unsigned PRESC   = (RAW_DIV < 1) ? 1 : RAW_DIV;

    logic              ctrl_run;
    logic [DUTY_W-1:0] ctrl_duty;
    logic [DUTY_W-1:0] step_cnt;
    logic              step_tick;

    assign bus_ready = 1'b1;

    fanpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .run      (ctrl_run),
        .duty     (ctrl_duty),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    fanpwm_prescaler #(.DIV(PRESC)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_run),
        .tick (step_tick)
    );

    fanpwm_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_run),
        .tick   (step_tick),
        .duty   (ctrl_duty),
        .step   (step_cnt),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/fanpwm_chk.sv
module fanpwm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic        bus_ready,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        run,
    input logic [7:0]  duty,
    input logic [7:0]  step,
    input logic        pwm_out
);
    AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready);                                                   // R5
    AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);                      // R5
    AST_NO_STRAY_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid);                    // R5
    AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[31:24] == 8'h00));                      // R2
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);                                           // R8
    AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (step == 8'd0));                               // R8
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step <= 8'd254);                                              // R6
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == 8'd255) |-> pwm_out);                         // R7
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == 8'd0) |-> !pwm_out);                                 // R7
endmodule

bind fanpwm_ctrl fanpwm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_ready(bus_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .run      (ctrl_run),
    .duty     (ctrl_duty),
    .step     (step_cnt),
    .pwm_out  (pwm_out)
);

// File: tb/sim_fanpwm_ctrl.sv
module sim_fanpwm_ctrl;
    localparam int unsigned CLK_HZ = 12750;   // gives 2 cycles per step
    localparam int          PER    = 510;     // 255 steps * 2

    // {control word, expected high cycles per period}
    localparam logic [47:0] VEC [8] = '{
        {32'h0000_0001, 16'd0},
        {32'h0001_0001, 16'd2},
        {32'h0040_0001, 16'd128},
        {32'h0080_0001, 16'd256},
        {32'h00C8_0003, 16'd400},
        {32'h00FE_0001, 16'd508},
        {32'h00FF_0001, 16'd510},
        {32'h0040_0003, 16'd128}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fanpwm_ctrl #(.CLK_HZ(CLK_HZ), .PERIOD_HZ(25), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    // samples one period starting at the current falling edge
    task automatic measure(output int highs, output int first_low);
        highs = 0;
        first_low = PER;
        for (int i = 0; i < PER; i++) begin
            if (pwm_out) highs++;
            else if (first_low == PER) first_low = i;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        v;
        int          h, fl, guard;

        repeat (4) @(negedge clk);
        chk("R1 out in reset", {31'b0, pwm_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out after reset", {31'b0, pwm_out}, 32'd0);
        bus_rd(4'h0, d, v);
        chk("R1 ctrl reset", d, 32'h0);
        chk("R5 rd_valid", {31'b0, v}, 32'd1);
        bus_rd(4'h4, d, v);
        chk("R1 speed reset", d, 32'h0);
        chk("R5 ready", {31'b0, bus_ready}, 32'd1);

        bus_wr(4'h4, 32'd4000);
        chk("R5 no rd_valid on write", {31'b0, rd_valid}, 32'd0);
        bus_rd(4'h4, d, v);
        chk("R3 speed 4000", d, 32'd4000);
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, d, v);
        chk("R3 speed upper bits", d, 32'h0000_FFFF);

        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, d, v);
        chk("R2 ctrl reserved bits", d, 32'h00FF_0003);
        bus_wr(4'h0, 32'h0);

        bus_wr(4'h8, 32'h1234_5678);
        bus_wr(4'hC, 32'hFFFF_FFFF);
        bus_rd(4'h8, d, v);
        chk("R4 read 0x8", d, 32'h0);
        bus_rd(4'hC, d, v);
        chk("R4 read 0xC", d, 32'h0);
        bus_rd(4'h0, d, v);
        chk("R4 ctrl untouched", d, 32'h0);
        bus_rd(4'h4, d, v);
        chk("R4 speed untouched", d, 32'h0000_FFFF);
        chk("R4 output untouched", {31'b0, pwm_out}, 32'd0);

        // table walk: R6, R7, R10
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            logic [15:0] e;
            w = VEC[k][47:16];
            e = VEC[k][15:0];
            bus_wr(4'h0, w);
            measure(h, fl);
            chk($sformatf("R7/R10 high cycles vec%0d", k), h, {16'b0, e});
            chk($sformatf("R7 first low vec%0d", k), fl, {16'b0, e});
            chk($sformatf("R6 next period start vec%0d", k), {31'b0, pwm_out},
                {31'b0, (e != 16'd0)});
            bus_rd(4'h0, d, v);
            chk($sformatf("R2 readback vec%0d", k), d, w & 32'h00FF_0003);
            bus_wr(4'h0, 32'h0);
        end

        // R8: stop mid-period, restart from step 0
        bus_wr(4'h0, 32'h0080_0001);
        repeat (100) @(negedge clk);
        chk("R7 high mid-period", {31'b0, pwm_out}, 32'd1);
        bus_wr(4'h0, 32'h0080_0000);
        chk("R8 stop forces low", {31'b0, pwm_out}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R8 stays low", {31'b0, pwm_out}, 32'd0);
        bus_wr(4'h0, 32'h0080_0001);
        measure(h, fl);
        chk("R8 restart first low", fl, 32'd256);
        chk("R8 restart high cycles", h, 32'd256);

        // R9: duty lowered mid-period
        bus_wr(4'h0, 32'h0);
        bus_wr(4'h0, 32'h00C8_0001);
        repeat (20) @(negedge clk);
        bus_wr(4'h0, 32'h0005_0001);
        chk("R9 new duty at once", {31'b0, pwm_out}, 32'd0);
        guard = 0;
        while (!pwm_out && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        measure(h, fl);
        chk("R9 next period high", h, 32'd10);
        chk("R9 next period first low", fl, 32'd10);
        measure(h, fl);
        chk("R9 later period high", h, 32'd10);

        finish_run();
    end
endmodule